// File: doc/BRIEF.md
# Multicart Unified Bank Switching Controller

This block maps ROM for a cartridge in an 8-bit console that has a 16-bit CPU address bus and a separate 14-bit picture-processor address bus. It keeps one 8-bit control byte. The CPU writes this byte by storing to any address in the upper half of its space. A 3-bit field of the byte selects the program bank and the character bank at the same time. The chosen 16 KiB program bank shows up in both halves of the upper CPU window. A low bit of the byte picks horizontal or vertical nametable mirroring.

The block combines the bank index with the low CPU address bits to form the program-ROM address. It combines the same index with the low picture address bits to form the character-ROM address. It also drives the ROM enables, the mirroring select line and the nametable RAM address bit 10. It has no interrupt source and no work RAM.

Top module: `mcart_bank_ctrl`

## Requirements
- R1: A CPU write (cpu_wr_n low) at the rising clock edge, with cpu_addr in 0x8000–0xFFFF, stores the whole cpu_wdata byte into the control byte. The new value shows on the outputs right after that edge. The stored byte is cpu_wdata as driven, and ROM data is not merged into it.
- R2: CPU writes with cpu_addr below 0x8000 leave every output unchanged.
- R3: The bank index is control bits [4:2]. Control bits [7:5] and bit 1 affect no output.
- R4: prg_addr = {bank, cpu_addr[13:0]} (17 bits). Because of this, 0x8000–0xBFFF and 0xC000–0xFFFF map to the same bank.
- R5: chr_addr = {bank, ppu_addr[12:0]} (16 bits).
- R6: mirror_horiz equals control bit 0, where 1 means horizontal and 0 means vertical. ntram_a10 equals ppu_addr[11] when the mode is horizontal and ppu_addr[10] when it is vertical.
- R7: While rst_n is low, the control byte is 0. This gives bank 0, vertical mirroring and mirror_horiz = 0.
- R8: prg_ce is 1 only when cpu_wr_n is high and cpu_addr[15] is 1. chr_ce is 1 only when ppu_addr[13] is 0.
- R9: irq_n is always 1, including after a write of 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| ppu_addr | input | 14 | Picture-processor address |
| prg_addr | output | 17 | Program-ROM address |
| prg_ce | output | 1 | Program-ROM enable |
| chr_addr | output | 16 | Character-ROM address |
| chr_ce | output | 1 | Character-ROM enable |
| mirror_horiz | output | 1 | 1 = horizontal mirroring |
| ntram_a10 | output | 1 | Nametable RAM address bit 10 |
| irq_n | output | 1 | Interrupt request, active low, always high |

## Verification
The bench writes all 256 byte values at addresses in both program windows. After each write it sweeps sample addresses and compares against values computed arithmetically. This sweep catches a bank field taken from the wrong bit slice. It also catches bits [7:5] or bit 1 leaking into the index, and a second window tied to a fixed last bank.

Writes at 0x7FFF and 0x0000 must leave the outputs as they were. A decoder on the wrong address bit would change the bank on those writes.

The bench checks the mirroring mux in both modes with picture address bits 10 and 11 set to opposite values. This exposes swapped mux inputs. It also checks the ROM enables at the window edges and the reset value that a mid-run reset returns to.

// File: rtl/mcart_pkg.sv
// Package: shared widths and the control-byte field layout for the bank controller.
// Assumes a 16-bit CPU bus, a 14-bit picture bus and 16 KiB / 8 KiB bank windows.
package mcart_pkg;
    localparam int CPU_AW   = 16;
    localparam int PPU_AW   = 14;
    localparam int BANK_W   = 3;
    localparam int PRG_OFSW = 14;
    localparam int CHR_OFSW = 13;
    localparam int PRG_AW   = BANK_W + PRG_OFSW;
    localparam int CHR_AW   = BANK_W + CHR_OFSW;
    localparam int BANK_LSB = 2;

    // Decoded view of the control byte
    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              horiz;
    } ctrl_t;

    // Extract decoded fields from a raw control byte
    function automatic ctrl_t decode_ctrl(input logic [7:0] raw);
        ctrl_t c;
        c.bank  = raw[BANK_LSB +: BANK_W];
        c.horiz = raw[0];
        return c;
    endfunction
endpackage

// File: rtl/mcart_ctrl_reg.sv
// Module: control-byte register. It latches the CPU data byte on a write in the
// upper half of CPU space. Assumes the write strobe is sampled at the rising clock edge.
module mcart_ctrl_reg
    import mcart_pkg::*;
#(
    parameter int AW = CPU_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic [7:0]    cpu_wdata,
    input  logic          cpu_wr_n,
    output ctrl_t         ctrl
);
    logic [7:0] raw_q;
    logic       hit;

    // Address decode: the upper half of CPU space selects the register
    always_comb hit = ~cpu_wr_n & cpu_addr[AW-1];

    // Register update with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n)   raw_q <= 8'h00;
        else if (hit) raw_q <= cpu_wdata;
    end

    // Field decode of the stored byte
    always_comb ctrl = decode_ctrl(raw_q);
endmodule

// File: rtl/mcart_prg_map.sv
// Module: program-side mapping. The same bank serves both 16 KiB halves of the
// upper window. Assumes only reads select the ROM.
module mcart_prg_map
    import mcart_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr_n,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_ce
);
    // Join bank to the in-window offset; address bit 14 is deliberately dropped
    always_comb begin
        prg_addr = {bank, cpu_addr[PRG_OFSW-1:0]};
        prg_ce   = cpu_wr_n & cpu_addr[CPU_AW-1];
    end
endmodule

// File: rtl/mcart_chr_map.sv
// Module: picture-side mapping. It forms the character-ROM address and enable
// and selects the nametable A10 line. Assumes pattern space is 0x0000-0x1FFF.
module mcart_chr_map
    import mcart_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic              horiz,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_ce,
    output logic              ntram_a10
);
    // Pattern address, pattern enable and mirroring mux
    always_comb begin
        chr_addr  = {bank, ppu_addr[CHR_OFSW-1:0]};
        chr_ce    = ~ppu_addr[PPU_AW-1];
        ntram_a10 = horiz ? ppu_addr[11] : ppu_addr[10];
    end
endmodule

// File: rtl/mcart_bank_ctrl.sv
// Module: top of the multicart bank controller. One control byte drives the program
// bank, the character bank and the mirroring. No interrupt and no work RAM.
module mcart_bank_ctrl
    import mcart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_wr_n,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic              prg_ce,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              chr_ce,
    output logic              mirror_horiz,
    output logic              ntram_a10,
    output logic              irq_n
);
    ctrl_t ctrl;

    mcart_ctrl_reg #(.AW(CPU_AW)) u_reg (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wr_n(cpu_wr_n), .ctrl(ctrl)
    );

    mcart_prg_map u_prg (
        .bank(ctrl.bank), .cpu_addr(cpu_addr), .cpu_wr_n(cpu_wr_n),
        .prg_addr(prg_addr), .prg_ce(prg_ce)
    );

    mcart_chr_map u_chr (
        .bank(ctrl.bank), .horiz(ctrl.horiz), .ppu_addr(ppu_addr),
        .chr_addr(chr_addr), .chr_ce(chr_ce), .ntram_a10(ntram_a10)
    );

    // Mirroring line and the permanently idle interrupt
    always_comb begin
        mirror_horiz = ctrl.horiz;
        irq_n        = 1'b1;
    end
endmodule

// File: rtl/mcart_bank_ctrl_chk.sv
// Checker: temporal properties of the bank controller, checked at its ports.
module mcart_bank_ctrl_chk
    import mcart_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [CPU_AW-1:0] cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_wr_n,
    input logic [PPU_AW-1:0] ppu_addr,
    input logic [PRG_AW-1:0] prg_addr,
    input logic [CHR_AW-1:0] chr_addr,
    input logic              mirror_horiz,
    input logic              irq_n
);
    // R1: an upper-half write is visible on the next cycle
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr_n && cpu_addr[15]) |=> (mirror_horiz == $past(cpu_wdata[0])
            && prg_addr[PRG_AW-1 -: BANK_W] == $past(cpu_wdata[4:2])));
    // R2: a lower-half write leaves the mirroring unchanged
    a_r2_low_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr_n && !cpu_addr[15]) |=> $stable(mirror_horiz));
    // R4/R5: the program and character banks agree
    a_r5_banks_agree: assert property (@(posedge clk) disable iff (!rst_n)
        prg_addr[PRG_AW-1 -: BANK_W] == chr_addr[CHR_AW-1 -: BANK_W]);
    // R7: the cycle after reset shows bank 0 and vertical mirroring
    a_r7_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mirror_horiz == 1'b0 && chr_addr[CHR_AW-1 -: BANK_W] == '0));
    // R9: the interrupt line never asserts
    a_r9_no_irq: assert property (@(posedge clk) irq_n == 1'b1);
endmodule

bind mcart_bank_ctrl mcart_bank_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr_n(cpu_wr_n), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
    .chr_addr(chr_addr), .mirror_horiz(mirror_horiz), .irq_n(irq_n)
);

// File: tb/mcart_bank_ctrl_tb.sv
module mcart_bank_ctrl_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_wr_n = 1;
    logic [13:0] ppu_addr = 0;
    logic [16:0] prg_addr;
    logic        prg_ce;
    logic [15:0] chr_addr;
    logic        chr_ce, mirror_horiz, ntram_a10, irq_n;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    mcart_bank_ctrl u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_wdata = d; cpu_wr_n = 0;
        @(negedge clk); cpu_wr_n = 1; cpu_addr = 16'h0000;
    endtask

    // Compare all outputs against the expected control byte
    task automatic check_state(input logic [7:0] c, input string req);
        int bank = (c >> 2) & 7;
        cpu_wr_n = 1;
        cpu_addr = 16'h8123; ppu_addr = 14'h0456; #1;
        chk({req, " R4 lo"}, prg_addr, bank * 16384 + 16'h0123);
        chk({req, " R5"}, chr_addr, bank * 8192 + 14'h0456);
        chk({req, " R6 mir"}, mirror_horiz, c & 1);
        cpu_addr = 16'hC123; #1;
        chk({req, " R4 hi"}, prg_addr, bank * 16384 + 16'h0123);
        ppu_addr = 14'h2800; #1;
        chk({req, " R6 a10"}, ntram_a10, (c & 1) ? 1 : 0);
        ppu_addr = 14'h2400; #1;
        chk({req, " R6 a10b"}, ntram_a10, (c & 1) ? 0 : 1);
        chk({req, " R9"}, irq_n, 1);
    endtask

    initial begin
        #200000;
        n_fail++; n_chk++;
        $display("FAIL watchdog act=hang exp=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] cur;
        repeat (3) @(negedge clk);
        check_state(8'h00, "R7 reset");
        rst_n = 1;
        // R1 R3: every byte, alternating window
        for (int v = 0; v < 256; v++) begin
            wr((v & 1) ? 16'hFFFF : 16'h8000, v[7:0]);
            check_state(v[7:0], "R1 R3 sweep");
        end
        cur = 8'hFF;
        // R9 after 0xFF
        chk("R9 ff", irq_n, 1);
        // R2: low writes ignored
        wr(16'h7FFF, 8'h00);
        check_state(cur, "R2 7fff");
        wr(16'h0000, 8'h10);
        check_state(cur, "R2 0000");
        // R8 enables
        cpu_wr_n = 1; cpu_addr = 16'h8000; #1; chk("R8 rd 8000", prg_ce, 1);
        cpu_addr = 16'h7FFF; #1; chk("R8 rd 7fff", prg_ce, 0);
        cpu_addr = 16'hFFFF; #1; chk("R8 rd ffff", prg_ce, 1);
        cpu_wr_n = 0; #1; chk("R8 wr", prg_ce, 0);
        cpu_wr_n = 1; cpu_addr = 16'h0000;
        ppu_addr = 14'h1FFF; #1; chk("R8 chr 1fff", chr_ce, 1);
        ppu_addr = 14'h2000; #1; chk("R8 chr 2000", chr_ce, 0);
        // R7: mid-run reset
        wr(16'hA000, 8'h15);
        check_state(8'h15, "R1 15");
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        check_state(8'h00, "R7 mid");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule